// File: doc/BRIEF.md
# Atomic Core Start Allocator

This block is the central launch controller for an array of sixteen processor cores. Any core may raise a start request that carries a control word, a 20-bit entry pointer and a 20-bit staged parameter. A round-robin arbiter accepts one request per cycle. The grant, the chosen core and any failure are reported in that same cycle. The allocation state changes at the next clock edge, so two requests can never be given the same idle core.

A request either asks for the lowest-numbered idle core or names a core directly. A named core is started whether it is idle or running, so a running core is restarted. On launch, the staged value goes to the target's first pointer register and the entry pointer goes to its second. In jump mode the target gets a start strobe in the next cycle with the entry pointer as its start address. In load mode the target is marked active but held. It then issues 504 sequential long-word fetches on its load port, starting at the second pointer. After the last fetch it receives a start strobe with start address zero.

Top module: `core_start_alloc`

## Requirements
- R1: `gnt_o` has at most one bit set in any cycle, and only for a requester whose `req_vld_i` bit is high.
- R2: Arbitration is round-robin. The search starts at the requester one above the last one granted, wraps after 15, and starts at 0 after reset.
- R3: When control bit 4 is 1, the target is the lowest-numbered core that is idle in the grant cycle. `rsp_id_o` returns that number and `rsp_fail_o` is 0.
- R4: When control bit 4 is 1 and all cores are active, `rsp_fail_o` is 1 and `rsp_id_o` is 15 (0xF). No core state changes.
- R5: When control bit 4 is 0, control bits 3:0 name the target. The target is launched even if it is already active, which restarts it, and `rsp_id_o` returns that number.
- R6: From the cycle after a successful grant, the target's `active_o` bit is 1. Its first pointer holds the staged value and its second pointer holds the entry pointer.
- R7: When control bit 5 is 1 (jump mode), the target's `start_o` bit pulses for one cycle, in the cycle after the grant. In that cycle its `start_pc_o` equals the entry pointer and it is not held.
- R8: When control bit 5 is 0 (load mode), the target is held (`held_o` and `ld_vld_o` are 1) for 504 cycles. During those cycles `ld_addr_o` equals the second pointer plus 4 times the beat index. In the next cycle `start_o` pulses with `start_pc_o` equal to 0.
- R9: Control bits 8:6 are reserved and have no effect on the outcome.
- R10: A `stop_i` bit makes that core idle in the next cycle and aborts any load in progress. A launch of the same core in the same cycle takes precedence over the stop.
- R11: After reset no core is active, held, loading or being started, and all pointer and start-address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 16 | Start request, one bit per requesting core |
| req_ctl_i | input | 144 | 9-bit control word per requester (bits 3:0 target, 4 pick-lowest-idle, 5 jump mode, 8:6 reserved) |
| req_src_i | input | 320 | 20-bit entry pointer per requester |
| req_stage_i | input | 320 | 20-bit staged parameter per requester |
| gnt_o | output | 16 | One-hot grant to the accepted requester |
| rsp_id_o | output | 4 | Core number given to the granted request (0xF on failure) |
| rsp_fail_o | output | 1 | No idle core was available |
| stop_i | input | 16 | Per-core stop strobe |
| active_o | output | 16 | Per-core active status |
| held_o | output | 16 | Core is active but held while its memory load runs |
| start_o | output | 16 | Per-core start strobe |
| start_pc_o | output | 320 | Start address per core, valid with its start strobe |
| ptra_o | output | 320 | First pointer register per core |
| ptrb_o | output | 320 | Second pointer register per core |
| ld_vld_o | output | 16 | Per-core load fetch valid toward hub memory |
| ld_addr_o | output | 320 | Per-core load fetch byte address |

## Verification
Some properties are checked by assertions on every cycle: the grant is one-hot and only goes to a requester, a failure is reported only when every core is active, a lowest-idle grant never lands on an active core, and a launched core is active on the next cycle. Per core, the assertions also check the jump-mode start address, entry into load mode with the first fetch address, no start strobe while held, and that a stop wins only when no launch arrives for that core. Other behaviour can only be shown by the bench's scenarios against its model. That covers the round-robin order across cycles and the full 504-beat load sequence ending in a start at zero. It also covers restarting a running core, and showing that reserved control bits and a stop coinciding with a launch leave the result unchanged.

// File: rtl/core_start_pkg.sv
package core_start_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_LOAD = 2'd1,
        SLOT_RUN  = 2'd2
    } slot_state_e;

    localparam int RSVD_W = 3;
endpackage

// File: rtl/start_rr_arbiter.sv
module start_rr_arbiter #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    typedef struct packed {
        logic [IW-1:0] rr;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        int c;
        arb_d = arb_q;
        any_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            c = (int'(arb_q.rr) + k) % N;
            if (!any_o && req_i[c]) begin
                any_o = 1'b1;
                idx_o = IW'(c);
            end
        end
        gnt_o = any_o ? (N'(1) << idx_o) : '0;
        if (any_o) begin
            arb_d.rr = IW'((int'(idx_o) + 1) % N);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R1
    gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/lowest_idle_finder.sv
module lowest_idle_finder #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  busy_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/core_launch_slot.sv
module core_launch_slot
    import core_start_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LOAD_LONGS = 504
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] stage_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic              stop_i,
    output logic              active_o,
    output logic              held_o,
    output logic              start_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] ptra_o,
    output logic [ADDR_W-1:0] ptrb_o,
    output logic              ld_vld_o,
    output logic [ADDR_W-1:0] ld_addr_o
);
    localparam int CNT_W = $clog2(LOAD_LONGS);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(LOAD_LONGS - 1);

    typedef struct packed {
        slot_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptra;
        logic [ADDR_W-1:0] ptrb;
        logic [ADDR_W-1:0] pc;
        logic              start;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d       = slot_q;
        slot_d.start = 1'b0;
        if (launch_i) begin
            slot_d.ptra = stage_i;
            slot_d.ptrb = src_i;
            slot_d.cnt  = '0;
            if (jump_i) begin
                slot_d.state = SLOT_RUN;
                slot_d.start = 1'b1;
                slot_d.pc    = src_i;
            end else begin
                slot_d.state = SLOT_LOAD;
            end
        end else if (stop_i) begin
            slot_d.state = SLOT_IDLE;
            slot_d.cnt   = '0;
        end else if (slot_q.state == SLOT_LOAD) begin
            if (slot_q.cnt == LAST_BEAT) begin
                slot_d.state = SLOT_RUN;
                slot_d.start = 1'b1;
                slot_d.pc    = '0;
                slot_d.cnt   = '0;
            end else begin
                slot_d.cnt = slot_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign active_o  = (slot_q.state != SLOT_IDLE);
    assign held_o    = (slot_q.state == SLOT_LOAD);
    assign ld_vld_o  = (slot_q.state == SLOT_LOAD);
    assign ld_addr_o = slot_q.ptrb + ADDR_W'({slot_q.cnt, 2'b00});
    assign start_o   = slot_q.start;
    assign pc_o      = slot_q.pc;
    assign ptra_o    = slot_q.ptra;
    assign ptrb_o    = slot_q.ptrb;

    // R6
    launch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> active_o && (ptra_o == $past(stage_i)) && (ptrb_o == $past(src_i)));
    // R7
    jump_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && jump_i) |=> start_o && !held_o && (pc_o == $past(src_i)));
    // R8
    load_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !jump_i) |=> held_o && ld_vld_o && (ld_addr_o == $past(src_i)));
    // R8
    held_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_o |-> !start_o);
    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !launch_i) |=> !active_o && !start_o);
endmodule

// File: rtl/core_start_alloc.sv
module core_start_alloc #(
    parameter int NCORE      = 16,
    parameter int ADDR_W     = 20,
    parameter int LOAD_LONGS = 504
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORE-1:0]         req_vld_i,
    input  logic [NCORE*(($clog2(NCORE))+5)-1:0] req_ctl_i,
    input  logic [NCORE*ADDR_W-1:0]  req_src_i,
    input  logic [NCORE*ADDR_W-1:0]  req_stage_i,
    output logic [NCORE-1:0]         gnt_o,
    output logic [$clog2(NCORE)-1:0] rsp_id_o,
    output logic                     rsp_fail_o,
    input  logic [NCORE-1:0]         stop_i,
    output logic [NCORE-1:0]         active_o,
    output logic [NCORE-1:0]         held_o,
    output logic [NCORE-1:0]         start_o,
    output logic [NCORE*ADDR_W-1:0]  start_pc_o,
    output logic [NCORE*ADDR_W-1:0]  ptra_o,
    output logic [NCORE*ADDR_W-1:0]  ptrb_o,
    output logic [NCORE-1:0]         ld_vld_o,
    output logic [NCORE*ADDR_W-1:0]  ld_addr_o
);
    localparam int IW       = $clog2(NCORE);
    localparam int FREE_BIT = IW;
    localparam int JUMP_BIT = IW + 1;
    localparam int CTL_W    = IW + 2 + core_start_pkg::RSVD_W;

    logic [IW-1:0]     win;
    logic              any_w;
    logic [CTL_W-1:0]  win_ctl;
    logic [ADDR_W-1:0] win_src;
    logic [ADDR_W-1:0] win_stage;
    logic [IW-1:0]     free_idx;
    logic              free_ok;
    logic [IW-1:0]     tgt;
    logic              fail;
    logic [NCORE-1:0]  launch_vec;

    start_rr_arbiter #(.N(NCORE), .IW(IW)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_vld_i),
        .gnt_o (gnt_o),
        .idx_o (win),
        .any_o (any_w)
    );

    lowest_idle_finder #(.N(NCORE), .IW(IW)) u_free (
        .busy_i  (active_o),
        .idx_o   (free_idx),
        .found_o (free_ok)
    );

    assign win_ctl   = req_ctl_i[win*CTL_W +: CTL_W];
    assign win_src   = req_src_i[win*ADDR_W +: ADDR_W];
    assign win_stage = req_stage_i[win*ADDR_W +: ADDR_W];

    always_comb begin
        tgt        = win_ctl[FREE_BIT] ? free_idx : win_ctl[IW-1:0];
        fail       = any_w && win_ctl[FREE_BIT] && !free_ok;
        launch_vec = (any_w && !fail) ? (NCORE'(1) << tgt) : '0;
        rsp_fail_o = fail;
        if (!any_w)    rsp_id_o = '0;
        else if (fail) rsp_id_o = '1;
        else           rsp_id_o = tgt;
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_slot
        core_launch_slot #(.ADDR_W(ADDR_W), .LOAD_LONGS(LOAD_LONGS)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .launch_i  (launch_vec[g]),
            .jump_i    (win_ctl[JUMP_BIT]),
            .stage_i   (win_stage),
            .src_i     (win_src),
            .stop_i    (stop_i[g]),
            .active_o  (active_o[g]),
            .held_o    (held_o[g]),
            .start_o   (start_o[g]),
            .pc_o      (start_pc_o[g*ADDR_W +: ADDR_W]),
            .ptra_o    (ptra_o[g*ADDR_W +: ADDR_W]),
            .ptrb_o    (ptrb_o[g*ADDR_W +: ADDR_W]),
            .ld_vld_o  (ld_vld_o[g]),
            .ld_addr_o (ld_addr_o[g*ADDR_W +: ADDR_W])
        );
    end

    known_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_w |-> !$isunknown(win_ctl));
    // R4
    fail_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail_o |-> (&active_o) && (|gnt_o));
    // R3
    free_pick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && !rsp_fail_o && win_ctl[FREE_BIT]) |-> !active_o[rsp_id_o]);
    // R6
    grant_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && !rsp_fail_o) |=> active_o[$past(rsp_id_o)]);
endmodule

// File: tb/sim_core_start_alloc.sv
module sim_core_start_alloc;
    localparam int N  = 16;
    localparam int AW = 20;
    localparam int CW = 9;
    localparam int LL = 504;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic [N-1:0]  req_vld, stop;
    logic [CW-1:0] ctl   [N];
    logic [AW-1:0] src   [N];
    logic [AW-1:0] stage [N];
    logic [N*CW-1:0] ctl_f;
    logic [N*AW-1:0] src_f, stage_f;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ctl_f[i*CW +: CW]   = ctl[i];
            src_f[i*AW +: AW]   = src[i];
            stage_f[i*AW +: AW] = stage[i];
        end
    end

    logic [N-1:0]    gnt_o, active_o, held_o, start_o, ld_vld_o;
    logic [3:0]      rsp_id_o;
    logic            rsp_fail_o;
    logic [N*AW-1:0] start_pc_o, ptra_o, ptrb_o, ld_addr_o;

    core_start_alloc u0 (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_ctl_i(ctl_f),
        .req_src_i(src_f), .req_stage_i(stage_f), .gnt_o(gnt_o),
        .rsp_id_o(rsp_id_o), .rsp_fail_o(rsp_fail_o), .stop_i(stop),
        .active_o(active_o), .held_o(held_o), .start_o(start_o),
        .start_pc_o(start_pc_o), .ptra_o(ptra_o), .ptrb_o(ptrb_o),
        .ld_vld_o(ld_vld_o), .ld_addr_o(ld_addr_o)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state (0 idle, 1 loading, 2 running)
    int            m_st  [N];
    int            m_cnt [N];
    logic [AW-1:0] m_pa  [N];
    logic [AW-1:0] m_pb  [N];
    logic [AW-1:0] m_pc  [N];
    bit            m_go  [N];
    int            m_rr;
    logic [N-1:0]  last_gnt;
    logic [3:0]    last_id;
    bit            last_fail;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] mk(input bit jump, input bit pick_free, input int t, input logic [2:0] rs);
        return {rs, jump, pick_free, 4'(t)};
    endfunction

    task automatic clr();
        req_vld = '0;
        stop    = '0;
        for (int i = 0; i < N; i++) begin
            ctl[i] = '0; src[i] = '0; stage[i] = '0;
        end
    endtask

    task automatic one_req(input int r, input logic [CW-1:0] c, input logic [AW-1:0] s, input logic [AW-1:0] p);
        clr();
        req_vld[r] = 1'b1;
        ctl[r] = c; src[r] = s; stage[r] = p;
    endtask

    task automatic step();
        int w, tgt;
        bit fail;
        logic [N-1:0] ea, eh, es;
        #2;
        w = -1;
        for (int k = 0; k < N; k++) begin
            if (w < 0 && req_vld[(m_rr + k) % N]) w = (m_rr + k) % N;
        end
        fail = 1'b0;
        tgt  = 0;
        if (w >= 0) begin
            if (ctl[w][4]) begin
                tgt = -1;
                for (int i = 0; i < N; i++) if (tgt < 0 && m_st[i] == 0) tgt = i;
                if (tgt < 0) begin fail = 1'b1; tgt = 15; end
            end else begin
                tgt = int'(ctl[w][3:0]);
            end
        end
        last_gnt = gnt_o; last_id = rsp_id_o; last_fail = rsp_fail_o;
        chk(gnt_o == ((w >= 0) ? (N'(1) << w) : '0), "R1 R2 grant", 32'(gnt_o), (w >= 0) ? (32'd1 << w) : 32'd0);
        chk(rsp_fail_o == fail, "R4 fail flag", 32'(rsp_fail_o), 32'(fail));
        if (w >= 0)
            chk(rsp_id_o == 4'(tgt), ctl[w][4] ? "R3 lowest idle id" : "R5 direct id", 32'(rsp_id_o), 32'(tgt));
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (w >= 0 && !fail && tgt == i) begin
                m_pa[i] = stage[w]; m_pb[i] = src[w]; m_cnt[i] = 0;
                if (ctl[w][5]) begin m_st[i] = 2; m_go[i] = 1'b1; m_pc[i] = src[w]; end
                else           begin m_st[i] = 1; m_go[i] = 1'b0; end
            end else if (stop[i]) begin
                m_st[i] = 0; m_cnt[i] = 0; m_go[i] = 1'b0;
            end else if (m_st[i] == 1) begin
                m_go[i] = 1'b0;
                if (m_cnt[i] == LL - 1) begin m_st[i] = 2; m_go[i] = 1'b1; m_pc[i] = '0; m_cnt[i] = 0; end
                else m_cnt[i]++;
            end else begin
                m_go[i] = 1'b0;
            end
        end
        if (w >= 0) m_rr = (w + 1) % N;
        @(negedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            ea[i] = (m_st[i] != 0); eh[i] = (m_st[i] == 1); es[i] = m_go[i];
        end
        chk(active_o == ea, "R6 R10 active", 32'(active_o), 32'(ea));
        chk(held_o == eh && ld_vld_o == eh, "R8 held/load valid", 32'(held_o), 32'(eh));
        chk(start_o == es, "R7 start strobe", 32'(start_o), 32'(es));
        for (int i = 0; i < N; i++) begin
            chk(ptra_o[i*AW +: AW] == m_pa[i] && ptrb_o[i*AW +: AW] == m_pb[i], "R6 pointers",
                32'(ptrb_o[i*AW +: AW]), 32'(m_pb[i]));
            if (es[i]) chk(start_pc_o[i*AW +: AW] == m_pc[i], "R7 R8 start address",
                32'(start_pc_o[i*AW +: AW]), 32'(m_pc[i]));
            if (eh[i]) chk(ld_addr_o[i*AW +: AW] == AW'(m_pb[i] + 20'(m_cnt[i] * 4)), "R8 load address",
                32'(ld_addr_o[i*AW +: AW]), 32'(AW'(m_pb[i] + 20'(m_cnt[i] * 4))));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst_n = 1'b0;
        clr();
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_pa[i] = '0; m_pb[i] = '0; m_pc[i] = '0; m_go[i] = 1'b0;
        end
        m_rr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(active_o == '0 && held_o == '0 && start_o == '0 && ld_vld_o == '0, "R11 status", 32'(active_o), 0);
        chk(ptra_o == '0 && ptrb_o == '0 && start_pc_o == '0 && gnt_o == '0, "R11 registers", 32'(ptra_o[19:0]), 0);

        // lowest-idle jump from requester 0
        one_req(0, mk(1, 1, 0, 3'b000), 20'h00AB0, 20'h11111);
        step();
        chk(start_o[0] && start_pc_o[19:0] == 20'h00AB0, "R7 jump start", 32'(start_pc_o[19:0]), 32'h00AB0);

        // reserved bits set on a direct jump
        one_req(4, mk(1, 0, 3, 3'b111), 20'h12345, 20'h0);
        step();
        chk(start_o[3] && active_o[3] && start_pc_o[3*AW +: AW] == 20'h12345, "R9 reserved ignored",
            32'(start_pc_o[3*AW +: AW]), 32'h12345);

        // two simultaneous requesters, rotation continues after requester 4
        clr();
        req_vld[2] = 1'b1; ctl[2] = mk(1, 0, 7, 3'b000); src[2] = 20'h70;
        req_vld[5] = 1'b1; ctl[5] = mk(1, 0, 8, 3'b000); src[5] = 20'h80;
        step();
        chk(last_gnt == 16'h0020, "R2 first of pair", 32'(last_gnt), 32'h20);
        step();
        chk(last_gnt == 16'h0004, "R2 wrap to lower", 32'(last_gnt), 32'h4);

        // fill the array, then a lowest-idle request must fail
        for (int t = 0; t < N; t++) begin
            one_req(1, mk(1, 0, t, 3'b000), 20'(t * 16), 20'(t));
            step();
        end
        one_req(7, mk(1, 1, 0, 3'b000), 20'h777, 20'h1);
        step();
        chk(last_fail && last_id == 4'hF, "R4 none idle", 32'(last_id), 32'hF);

        // stop frees a core which the next lowest-idle request receives
        clr(); stop[6] = 1'b1;
        step();
        chk(!active_o[6], "R10 stop clears", 32'(active_o[6]), 0);
        one_req(2, mk(1, 1, 0, 3'b000), 20'h555, 20'h0);
        step();
        chk(!last_fail && last_id == 4'd6, "R3 freed core chosen", 32'(last_id), 6);

        // launch and stop of the same core in one cycle
        one_req(3, mk(1, 0, 9, 3'b000), 20'h999, 20'h0);
        stop[9] = 1'b1;
        step();
        chk(active_o[9] && start_o[9], "R10 launch beats stop", 32'(active_o[9]), 1);

        // restart running core 9 in load mode and run the whole copy
        one_req(0, mk(0, 0, 9, 3'b000), 20'h00100, 20'h00042);
        step();
        chk(held_o[9] && ld_addr_o[9*AW +: AW] == 20'h00100 && ptra_o[9*AW +: AW] == 20'h42, "R5 restart into load",
            32'(ld_addr_o[9*AW +: AW]), 32'h100);
        clr();
        repeat (LL - 1) step();
        chk(held_o[9] && !start_o[9], "R8 still held on last beat", 32'(held_o[9]), 1);
        step();
        chk(start_o[9] && !held_o[9] && start_pc_o[9*AW +: AW] == '0, "R8 start at zero",
            32'(start_pc_o[9*AW +: AW]), 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < N; i++) begin
                req_vld[i] = ($urandom % 8) == 0;
                ctl[i]     = mk(($urandom % 16) != 0, ($urandom % 2) == 1, int'($urandom % 16), 3'($urandom));
                src[i]     = 20'($urandom);
                stage[i]   = 20'($urandom);
                stop[i]    = ($urandom % 64) == 0;
            end
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule